// File: doc/BRIEF.md
# Phase-Corrected Fractional Clock Divider

This block turns one fast source clock into several slower clocks, each set by its own ratio N + F/D, where N is the integer part, F the numerator and D the denominator of the fraction. Every output period lasts either N or N+1 source cycles. A remainder register that steps by F modulo D picks between the two lengths, so the long-run average period equals the programmed ratio with no frequency error.

Every divided-clock rising edge lands early compared with the ideal waveform. With each edge the block emits an 8-bit correction word, the remaining lag as a fraction of one source period. A downstream fine-delay element can use this word to move the edge onto its ideal position. The remainder has 30 bits, which resolves the ratio to better than one part per billion.

Each channel is in one of two states, stopped or running. A stopped channel samples its ratio inputs on every source cycle. A running channel samples them only at the end of a period. An illegal ratio stops the channel and raises an error flag.

Top module: `frac_clk_div`

## Requirements
- R1: Counting periods from k = 1 after a ratio is loaded, period k lasts N + floor(k·F/D) − floor((k−1)·F/D) source cycles, so every period is N or N+1 cycles long.
- R2: The first D periods after a load add up to exactly N·D + F source cycles.
- R3: At the rising edge that starts period k+1, the correction word equals floor(256·((k·F) mod D)/D). At the first edge after a stopped channel starts, it is 0. The word changes only in a cycle where the strobe is high.
- R4: The edge strobe is high for exactly one source cycle: the first high cycle of the divided clock. In a period of L cycles, the divided clock is high for the first floor(L/2) cycles and low for the rest.
- R5: A ratio is illegal when N < 4, D = 0 or F ≥ D. When an illegal ratio is sampled, the error flag goes high and the channel stops. A stopped channel holds its divided clock and strobe low until a legal ratio is sampled.
- R6: A stopped channel that samples a legal ratio raises its divided clock and strobe on the next source edge. This starts period 1.
- R7: While a channel runs, a ratio change takes effect only at the next divided-clock rising edge. The period in progress keeps its length. Loading the new ratio clears the remainder, so the new ratio's periods follow R1 and R3 from k = 1.
- R8: Four channels share one source clock. Each channel follows R1–R7 for its own ratio, without influence from the others.
- R9: N ranges from 4 to 255, so the longest period is 256 cycles. D can be as large as 2^30 − 1; a denominator of 10^9 gives 1 ppb steps.
- R10: While reset is held, all divided clocks, strobes, error flags and correction words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock shared by all channels |
| rst_n | input | 1 | Synchronous active-low reset |
| div_int | input | NCH×IW | Integer part N of each channel's ratio |
| div_num | input | NCH×FW | Numerator F of each channel's fraction |
| div_den | input | NCH×FW | Denominator D of each channel's fraction |
| clk_div | output | NCH | Divided clock per channel |
| edge_vld | output | NCH | One-cycle strobe at each divided-clock rising edge |
| phase_corr | output | NCH×CW | Correction word for that edge, in 1/256 of a source period |
| cfg_err | output | NCH | Illegal-ratio flag per channel |

## Verification
The bench builds the block with its default parameters: four channels, an 8-bit integer part, a 30-bit fraction and an 8-bit correction word. With an 8-bit integer part, the 256-cycle period at N = 255 can be reached in a short run. The 30-bit fraction admits a denominator of 10^9, which exercises the one-ppb corner and the full-width remainder arithmetic. Because four channels are present, the bench can drive different ratios at once, including a change while a channel runs and an illegal ratio loaded over a running one.

// File: rtl/frac_div_pkg.sv
// Shared defaults and the channel state type for the fractional divider.
package frac_div_pkg;
    localparam int unsigned CHAN_DEF   = 4;
    localparam int unsigned INT_W_DEF  = 8;
    localparam int unsigned FRAC_W_DEF = 30;
    localparam int unsigned CORR_W_DEF = 8;
    localparam int unsigned MIN_INT    = 4;

    typedef enum logic {
        CH_STOPPED = 1'b0,
        CH_RUNNING = 1'b1
    } chan_state_e;
endpackage

// File: rtl/fdiv_cfg_check.sv
// Checks a requested ratio and compares it with the ratio in use.
// Assumes: purely combinational; the caller decides when to act on it.
module fdiv_cfg_check #(
    parameter int unsigned IW      = 8,
    parameter int unsigned FW      = 30,
    parameter int unsigned MIN_INT = 4
) (
    input  logic [IW-1:0] req_int,
    input  logic [FW-1:0] req_num,
    input  logic [FW-1:0] req_den,
    input  logic [IW-1:0] act_int,
    input  logic [FW-1:0] act_num,
    input  logic [FW-1:0] act_den,
    output logic          cfg_ok,
    output logic          cfg_new
);
    localparam logic [IW-1:0] INT_FLOOR = IW'(MIN_INT);

    // Legal ratio: integer part large enough, fraction proper and defined.
    always_comb begin
        cfg_ok = (req_int >= INT_FLOOR) && (req_den != '0) && (req_num < req_den);
    end

    // Any field differing from the active ratio counts as a new ratio.
    always_comb begin
        cfg_new = {req_int, req_num, req_den} != {act_int, act_num, act_den};
    end
endmodule

// File: rtl/fdiv_mod_acc.sv
// One step of the modulo-D remainder: adds F and wraps at D.
// Assumes acc < den and num < den, so one subtraction suffices.
module fdiv_mod_acc #(
    parameter int unsigned FW = 30
) (
    input  logic [FW-1:0] acc,
    input  logic [FW-1:0] num,
    input  logic [FW-1:0] den,
    output logic [FW-1:0] acc_next,
    output logic          carry
);
    logic [FW:0] sum;
    logic [FW:0] den_x;
    logic [FW:0] diff;

    // Widened sum, then a single conditional wrap.
    always_comb begin
        sum      = {1'b0, acc} + {1'b0, num};
        den_x    = {1'b0, den};
        diff     = sum - den_x;
        carry    = (sum >= den_x);
        acc_next = carry ? diff[FW-1:0] : sum[FW-1:0];
    end
endmodule

// File: rtl/fdiv_phase_scale.sv
// Scales a remainder to a CW-bit fraction of one source period:
// word = floor(residue * 2^CW / den), by restoring division.
// Assumes residue < den; one compare-subtract stage per output bit.
module fdiv_phase_scale #(
    parameter int unsigned FW = 30,
    parameter int unsigned CW = 8
) (
    input  logic [FW-1:0] residue,
    input  logic [FW-1:0] den,
    output logic [CW-1:0] word
);
    logic [FW-1:0] rem [CW];

    assign rem[0] = residue;

    for (genvar i = 0; i < CW; i++) begin : g_stage
        logic [FW:0] sh;
        logic [FW:0] sub;
        logic        ge;
        // Shift in one quotient bit position and try the subtraction.
        always_comb begin
            sh  = {rem[i], 1'b0};
            sub = sh - {1'b0, den};
            ge  = (sh >= {1'b0, den});
        end
        assign word[CW-1-i] = ge;
        if (i < CW - 1) begin : g_next
            assign rem[i+1] = ge ? sub[FW-1:0] : sh[FW-1:0];
        end
    end
endmodule

// File: rtl/fdiv_chan.sv
// One divider channel: period counter, remainder step, ratio
// shadow and the registered divided clock, strobe and correction.
// Assumes one source clock and a synchronous active-low reset.
// A stopped channel samples its ratio every cycle; a running one
// samples it only on the last cycle of each period.
module fdiv_chan
    import frac_div_pkg::*;
#(
    parameter int unsigned IW      = 8,
    parameter int unsigned FW      = 30,
    parameter int unsigned CW      = 8,
    parameter int unsigned MIN_INT = 4
) (
    input  logic          clk_src,
    input  logic          rst_n,
    input  logic [IW-1:0] req_int,
    input  logic [FW-1:0] req_num,
    input  logic [FW-1:0] req_den,
    output logic          clk_div,
    output logic          edge_vld,
    output logic [CW-1:0] phase_corr,
    output logic          cfg_err
);
    localparam int unsigned LW = IW + 1;

    chan_state_e   state;
    logic [LW-1:0] cnt;
    logic [LW-1:0] plen;
    logic [IW-1:0] act_int;
    logic [FW-1:0] act_num;
    logic [FW-1:0] act_den;
    logic [FW-1:0] acc;
    logic          clk_q;
    logic          vld_q;
    logic [CW-1:0] corr_q;
    logic          err_q;

    logic          running;
    logic          at_end;
    logic          take_cfg;
    logic [LW-1:0] cnt_inc;
    logic [LW-1:0] half;
    logic          cfg_ok;
    logic          cfg_new;
    logic [FW-1:0] acc_next;
    logic          carry;
    logic [CW-1:0] scale_word;

    fdiv_cfg_check #(.IW(IW), .FW(FW), .MIN_INT(MIN_INT)) u_check (
        .req_int (req_int),
        .req_num (req_num),
        .req_den (req_den),
        .act_int (act_int),
        .act_num (act_num),
        .act_den (act_den),
        .cfg_ok  (cfg_ok),
        .cfg_new (cfg_new)
    );

    fdiv_mod_acc #(.FW(FW)) u_acc (
        .acc      (acc),
        .num      (act_num),
        .den      (act_den),
        .acc_next (acc_next),
        .carry    (carry)
    );

    fdiv_phase_scale #(.FW(FW), .CW(CW)) u_scale (
        .residue (acc),
        .den     (act_den),
        .word    (scale_word)
    );

    // Period bookkeeping decoded from the counter.
    always_comb begin
        running  = (state == CH_RUNNING);
        at_end   = running && (cnt == plen - 1'b1);
        take_cfg = !running || at_end;
        cnt_inc  = cnt + 1'b1;
        half     = plen >> 1;
    end

    // Channel state: start, stop, reload or advance one source cycle.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            state   <= CH_STOPPED;
            cnt     <= '0;
            plen    <= '0;
            act_int <= '0;
            act_num <= '0;
            act_den <= '0;
            acc     <= '0;
            clk_q   <= 1'b0;
            vld_q   <= 1'b0;
            corr_q  <= '0;
            err_q   <= 1'b0;
        end else if (take_cfg) begin
            if (!cfg_ok) begin
                state <= CH_STOPPED;
                cnt   <= '0;
                acc   <= '0;
                clk_q <= 1'b0;
                vld_q <= 1'b0;
                err_q <= 1'b1;
            end else begin
                state  <= CH_RUNNING;
                cnt    <= '0;
                clk_q  <= 1'b1;
                vld_q  <= 1'b1;
                err_q  <= 1'b0;
                corr_q <= running ? scale_word : '0;
                if (!running || cfg_new) begin
                    act_int <= req_int;
                    act_num <= req_num;
                    act_den <= req_den;
                    plen    <= {1'b0, req_int};
                    acc     <= req_num;
                end else begin
                    plen <= {1'b0, act_int} + {{IW{1'b0}}, carry};
                    acc  <= acc_next;
                end
            end
        end else begin
            cnt   <= cnt_inc;
            vld_q <= 1'b0;
            clk_q <= (cnt_inc < half);
        end
    end

    assign clk_div    = clk_q;
    assign edge_vld   = vld_q;
    assign phase_corr = corr_q;
    assign cfg_err    = err_q;
endmodule

// File: rtl/frac_clk_div.sv
// Top: NCH independent fractional divider channels on one source clock.
// Assumes ratio inputs are synchronous to clk_src.
module frac_clk_div
    import frac_div_pkg::*;
#(
    parameter int unsigned NCH = CHAN_DEF,
    parameter int unsigned IW  = INT_W_DEF,
    parameter int unsigned FW  = FRAC_W_DEF,
    parameter int unsigned CW  = CORR_W_DEF
) (
    input  logic                   clk_src,
    input  logic                   rst_n,
    input  logic [NCH-1:0][IW-1:0] div_int,
    input  logic [NCH-1:0][FW-1:0] div_num,
    input  logic [NCH-1:0][FW-1:0] div_den,
    output logic [NCH-1:0]         clk_div,
    output logic [NCH-1:0]         edge_vld,
    output logic [NCH-1:0][CW-1:0] phase_corr,
    output logic [NCH-1:0]         cfg_err
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        fdiv_chan #(.IW(IW), .FW(FW), .CW(CW), .MIN_INT(MIN_INT)) u_chan (
            .clk_src    (clk_src),
            .rst_n      (rst_n),
            .req_int    (div_int[c]),
            .req_num    (div_num[c]),
            .req_den    (div_den[c]),
            .clk_div    (clk_div[c]),
            .edge_vld   (edge_vld[c]),
            .phase_corr (phase_corr[c]),
            .cfg_err    (cfg_err[c])
        );
    end
endmodule

// File: rtl/frac_clk_div_chk.sv
// Property checker for frac_clk_div, attached by bind below.
module frac_clk_div_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 8
) (
    input logic                   clk_src,
    input logic                   rst_n,
    input logic [NCH-1:0]         clk_div,
    input logic [NCH-1:0]         edge_vld,
    input logic [NCH-1:0][CW-1:0] phase_corr,
    input logic [NCH-1:0]         cfg_err
);
    for (genvar g = 0; g < NCH; g++) begin : g_prop
        p_vld_with_rise_r4: assert property (@(posedge clk_src) disable iff (!rst_n)
            edge_vld[g] |-> (clk_div[g] && !$past(clk_div[g])));
        p_strobe_single_r4: assert property (@(posedge clk_src) disable iff (!rst_n)
            edge_vld[g] |=> !edge_vld[g]);
        p_err_silent_r5: assert property (@(posedge clk_src) disable iff (!rst_n)
            cfg_err[g] |-> (!clk_div[g] && !edge_vld[g]));
        p_corr_moves_on_edge_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
            !$stable(phase_corr[g]) |-> edge_vld[g]);
        p_high_min_r1: assert property (@(posedge clk_src) disable iff (!rst_n)
            $fell(clk_div[g]) |-> $past(clk_div[g], 2));
    end
endmodule

bind frac_clk_div frac_clk_div_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk_src    (clk_src),
    .rst_n      (rst_n),
    .clk_div    (clk_div),
    .edge_vld   (edge_vld),
    .phase_corr (phase_corr),
    .cfg_err    (cfg_err)
);

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
    localparam int NCH = 4;
    localparam int IW  = 8;
    localparam int FW  = 30;
    localparam int CW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0][IW-1:0] div_int;
    logic [NCH-1:0][FW-1:0] div_num;
    logic [NCH-1:0][FW-1:0] div_den;
    logic [NCH-1:0]         clk_div;
    logic [NCH-1:0]         edge_vld;
    logic [NCH-1:0][CW-1:0] phase_corr;
    logic [NCH-1:0]         cfg_err;

    logic [IW-1:0] t_int [NCH];
    logic [FW-1:0] t_num [NCH];
    logic [FW-1:0] t_den [NCH];

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    for (genvar g = 0; g < NCH; g++) begin : g_drv
        assign div_int[g] = t_int[g];
        assign div_num[g] = t_num[g];
        assign div_den[g] = t_den[g];
    end

    frac_clk_div #(.NCH(NCH), .IW(IW), .FW(FW), .CW(CW)) u_dut (
        .clk_src    (clk),
        .rst_n      (rst_n),
        .div_int    (div_int),
        .div_num    (div_num),
        .div_den    (div_den),
        .clk_div    (clk_div),
        .edge_vld   (edge_vld),
        .phase_corr (phase_corr),
        .cfg_err    (cfg_err)
    );

    function automatic longint exp_len(longint n, longint f, longint d, longint k);
        return n + (k * f) / d - ((k - 1) * f) / d;
    endfunction

    function automatic longint exp_corr(longint f, longint d, longint k);
        return (((k * f) % d) * 256) / d;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(int ch, longint n, longint f, longint d);
        t_int[ch] = IW'(n);
        t_num[ch] = FW'(f);
        t_den[ch] = FW'(d);
    endtask

    // Bring a channel to the stopped state with an illegal ratio.
    task automatic stop_ch(int ch);
        int guard = 0;
        set_cfg(ch, 0, 0, 0);
        @(negedge clk);
        while (!cfg_err[ch] && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        chk("R5", "stop reached", longint'(cfg_err[ch]), 1);
    endtask

    // Called at the negedge where the strobe of period 1 is seen.
    task automatic measure(int ch, longint n, longint f, longint d, int nper);
        longint total = 0;
        for (int k = 1; k <= nper; k++) begin
            int len = 1;
            int high = int'(clk_div[ch]);
            bit seen = 0;
            while (!seen && len < 600) begin
                @(negedge clk);
                if (edge_vld[ch]) seen = 1;
                else begin
                    len++;
                    if (clk_div[ch]) high++;
                end
            end
            chk("R1", $sformatf("ch%0d period %0d length", ch, k), len, exp_len(n, f, d, k));
            chk("R4", $sformatf("ch%0d period %0d high cycles", ch, k), high, len / 2);
            chk("R3", $sformatf("ch%0d edge %0d correction", ch, k),
                longint'(phase_corr[ch]), exp_corr(f, d, k));
            if (k <= d) total += len;
            if (k == d) chk("R2", $sformatf("ch%0d sum over D periods", ch), total, n * d + f);
        end
    endtask

    // Start from stopped with a legal ratio and check nper periods.
    task automatic run_ratio(int ch, longint n, longint f, longint d, int nper);
        stop_ch(ch);
        set_cfg(ch, n, f, d);
        @(negedge clk);
        chk("R6", $sformatf("ch%0d start strobe", ch), longint'(edge_vld[ch]), 1);
        chk("R6", $sformatf("ch%0d start clock high", ch), longint'(clk_div[ch]), 1);
        chk("R3", $sformatf("ch%0d first correction", ch), longint'(phase_corr[ch]), 0);
        chk("R5", $sformatf("ch%0d error clear", ch), longint'(cfg_err[ch]), 0);
        measure(ch, n, f, d, nper);
    endtask

    // An illegal ratio on a stopped channel keeps it silent.
    task automatic illegal_case(int ch, longint n, longint f, longint d, string what);
        int act_cnt = 0;
        stop_ch(ch);
        set_cfg(ch, n, f, d);
        repeat (3) @(negedge clk);
        chk("R5", {what, " error flag"}, longint'(cfg_err[ch]), 1);
        repeat (30) begin
            @(negedge clk);
            if (clk_div[ch] || edge_vld[ch]) act_cnt++;
        end
        chk("R5", {what, " outputs quiet"}, act_cnt, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed;
        for (int c = 0; c < NCH; c++) set_cfg(c, 0, 0, 0);
        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10", "clk_div in reset", longint'(clk_div), 0);
        chk("R10", "edge_vld in reset", longint'(edge_vld), 0);
        chk("R10", "cfg_err in reset", longint'(cfg_err), 0);
        chk("R10", "phase_corr in reset", longint'(phase_corr), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5", "zero ratio after reset flags error", longint'(cfg_err), 4'hF);

        // R1 R3 R4: directed ratios
        run_ratio(0, 4, 0, 1, 6);
        run_ratio(0, 7, 1, 2, 8);
        run_ratio(1, 5, 2, 3, 7);
        run_ratio(2, 9, 5, 7, 15);
        // R9: one-ppb denominator and longest period
        run_ratio(0, 4, 999999999, 1000000000, 3);
        run_ratio(3, 4, 1, 1000000000, 3);
        run_ratio(1, 255, 1, 3, 4);

        // R5: illegal ratios
        illegal_case(0, 3, 0, 1, "N below 4");
        illegal_case(0, 6, 0, 0, "zero D");
        illegal_case(0, 6, 5, 5, "F equal D");

        // R7: change mid-period, remainder cleared at the load
        stop_ch(0);
        set_cfg(0, 5, 2, 3);
        @(negedge clk);
        repeat (2) @(negedge clk);
        set_cfg(0, 6, 1, 3);
        begin
            int len = 3;
            while (!edge_vld[0] && len < 600) begin
                @(negedge clk);
                if (!edge_vld[0]) len++;
            end
            chk("R7", "period in progress kept", len, 5);
            chk("R7", "correction at load edge", longint'(phase_corr[0]), 170);
        end
        measure(0, 6, 1, 3, 4);

        // R7 R5: illegal ratio while running waits for the period end
        stop_ch(0);
        set_cfg(0, 8, 0, 1);
        @(negedge clk);
        @(negedge clk);
        set_cfg(0, 2, 0, 1);
        begin
            int len = 2;
            int extra = 0;
            while (!cfg_err[0] && len < 600) begin
                @(negedge clk);
                if (edge_vld[0]) extra++;
                if (!cfg_err[0]) len++;
            end
            chk("R7", "running period ends before stop", len, 8);
            chk("R7", "no strobe before stop", extra, 0);
            chk("R5", "clock low after stop", longint'(clk_div[0]), 0);
        end

        // R8: four channels at once with distinct ratios
        fork
            run_ratio(0, 4, 1, 3, 6);
            run_ratio(1, 6, 4, 5, 10);
            run_ratio(2, 11, 3, 8, 16);
            run_ratio(3, 5, 0, 1, 12);
        join

        // R1 R2 R3: random ratios from a fixed seed
        seed = $urandom(32'd20240607);
        for (int i = 0; i < 12; i++) begin
            int ch = int'($urandom_range(NCH - 1, 0));
            longint n = longint'($urandom_range(20, 4));
            longint d = longint'($urandom_range(40, 1));
            longint f = longint'($urandom_range(int'(d - 1), 0));
            run_ratio(ch, n, f, d, int'(d) + 1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule